// File: doc/BRIEF.md
# Alignable PWM Channel Generator

This block produces one pulse-width-modulated waveform from a free-running channel counter. A 4-bit clock-select input decides how often the counter advances. The choices are the module clock divided by a power of two from 1 to 1024, or the tick of one of two independent linear dividers, each programmed with an 8-bit factor. On every tick the counter moves one step. It is compared with a period value and a duty value, and the result gives the output level.

Two counting shapes are available. In edge (left-aligned) mode the counter runs 0 to period-1 and wraps. In center-aligned mode it climbs from 0 to the period value and falls back to 0, so the waveform period is twice as long. Period, duty and alignment are copied into shadow registers only at the period boundary, so a waveform in progress is never cut short. A polarity input picks the level driven in the duty region. While the enable input is low, the counter rests at 0 and the output sits at its inactive level.

Top module: `pwm_channel`

## Requirements
- R1: Clock-select codes 0 to 10 advance the counter once every 2^code module clocks. In left-aligned mode the waveform period is therefore 2^code × P module clocks, where P is the period value.
- R2: Clock-select code 11 takes its tick from divider A and code 12 from divider B. A divider factor N in the range 1 to 255 gives one tick every N clocks. Factor 0 produces no tick, and codes 13 to 15 also produce no tick. Without ticks the counter and the output hold still.
- R3: In left-aligned mode (center input 0) the counter counts 0 to P-1 and wraps. The output is in the duty region while the counter is at or above the duty value D, which gives divisor × (P−D) duty cycles per divisor × P cycles.
- R4: In center-aligned mode (center input 1) the counter rises to P and falls back to 0. The period is 2 × divisor × P cycles, and the duty region covers 2 × divisor × (P−D) of them in one contiguous run.
- R5: D = 0 keeps the output in the duty region at all times. D ≥ P keeps it out of the duty region at all times. Neither case produces any pulse.
- R6: New period, duty and alignment values take effect only at a period boundary: the wrap in left-aligned mode, or the return to zero in center-aligned mode. They also take effect while the channel is disabled.
- R7: While enable is low the counter is 0 and the output equals the inverse of the polarity input. This is also the state after reset.
- R8: The output level in the duty region equals the polarity input, so with polarity 0 the output is low for divisor × (P−D) cycles of each left-aligned period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| center_i | input | 1 | 1 selects center-aligned counting, 0 selects left-aligned |
| pol_i | input | 1 | Output level in the duty region |
| clk_sel_i | input | 4 | Tick source: 0–10 power-of-two prescale, 11 divider A, 12 divider B, 13–15 off |
| div_a_i | input | 8 | Factor of linear divider A (0 = off) |
| div_b_i | input | 8 | Factor of linear divider B (0 = off) |
| period_i | input | 16 | Period value P |
| duty_i | input | 16 | Duty value D |
| pwm_o | output | 1 | Waveform output |

## Verification
The assertions assume that the register inputs are ordinary synchronous levels. They allow a value to change in any cycle, because the shadow registers are expected to hide every change until a boundary. The assertions on counter range assume the shadow period is nonzero whenever they apply. The bench changes settings only while the channel is disabled, except in the one directed test that changes the duty value on purpose in the middle of a period. Random trials keep P between 2 and 40 and D strictly between 0 and P, and they limit the divisor so that every measured period stays within a few thousand clocks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_SEL_W    = 4;
  localparam int unsigned PWM_PRE_NUM  = 11;
  localparam logic [PWM_SEL_W-1:0] PWM_SEL_DIV_A = 4'd11;
  localparam logic [PWM_SEL_W-1:0] PWM_SEL_DIV_B = 4'd12;
  localparam int unsigned PWM_ARG_W    = 32;

  // Duty-region decision shared by both alignments.
  function automatic logic pwm_in_duty(input logic [PWM_ARG_W-1:0] cnt,
                                       input logic [PWM_ARG_W-1:0] duty,
                                       input logic [PWM_ARG_W-1:0] period,
                                       input logic center,
                                       input logic down);
    logic r;
    if (duty == '0)           r = 1'b1;
    else if (duty >= period)  r = 1'b0;
    else if (center && !down) r = (cnt > duty);
    else                      r = (cnt >= duty);
    return r;
  endfunction
endpackage

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] factor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] q;
  logic             at_end;

  assign at_end = (factor_i != '0) && (q >= factor_i - 1'b1);
  assign tick_o = en_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        q <= '0;
    else if (!en_i || factor_i == '0)   q <= '0;
    else if (at_end)                    q <= '0;
    else                                q <= q + 1'b1;
  end

  // R2: a divider with factor 0 never ticks
  p_div_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (factor_i == '0) |=> (q == '0));
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned PRE_NUM = PWM_PRE_NUM
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [PWM_SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0]     div_a_i,
  input  logic [DIV_W-1:0]     div_b_i,
  output logic                 tick_o
);
  localparam int unsigned PRE_W = (PRE_NUM > 1) ? PRE_NUM - 1 : 1;

  logic [PRE_W-1:0]   pre_q;
  logic [PRE_NUM-1:0] pre_tick;
  logic               tick_a, tick_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!en_i)  pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // Stage k fires once every 2^k clocks.
  genvar k;
  generate
    for (k = 0; k < PRE_NUM; k++) begin : g_pre
      if (k == 0) begin : g_unit
        assign pre_tick[k] = en_i;
      end else begin : g_pow
        assign pre_tick[k] = en_i && (&pre_q[k-1:0]);
      end
    end
  endgenerate

  pwm_lin_div #(.DIV_W(DIV_W)) u_div_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .factor_i(div_a_i), .tick_o(tick_a));

  pwm_lin_div #(.DIV_W(DIV_W)) u_div_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .factor_i(div_b_i), .tick_o(tick_b));

  always_comb begin
    if (32'(sel_i) < PRE_NUM)        tick_o = pre_tick[sel_i];
    else if (sel_i == PWM_SEL_DIV_A) tick_o = tick_a;
    else if (sel_i == PWM_SEL_DIV_B) tick_o = tick_b;
    else                             tick_o = 1'b0;
  end

  // R2: unused select codes give no tick
  p_sel_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > PWM_SEL_DIV_B) |-> !tick_o);
  // R1: the undivided code ticks on every enabled cycle
  p_sel_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             down_o,
  output logic             center_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, per_s, duty_s;
  logic             down_q, down_n, center_s, load;

  always_comb begin
    cnt_n  = cnt_q;
    down_n = down_q;
    load   = 1'b0;
    if (!en_i) begin
      cnt_n = '0; down_n = 1'b0; load = 1'b1;
    end else if (tick_i) begin
      if (per_s == '0) begin
        cnt_n = '0; down_n = 1'b0; load = 1'b1;
      end else if (!center_s) begin
        if ({1'b0, cnt_q} + 1'b1 >= {1'b0, per_s}) begin
          cnt_n = '0; load = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (cnt_q >= per_s) begin
          if (per_s == CNT_W'(1)) begin
            cnt_n = '0; load = 1'b1;
          end else begin
            cnt_n = cnt_q - 1'b1; down_n = 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_n = '0; down_n = 1'b0; load = 1'b1;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; down_q <= 1'b0;
      per_s <= '0; duty_s <= '0; center_s <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      if (load) begin
        per_s    <= period_i;
        duty_s   <= duty_i;
        center_s <= center_i;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign down_o   = down_q;
  assign center_o = center_s;
  assign per_o    = per_s;
  assign duty_o   = duty_s;
  assign load_o   = load;

  // R3: left-aligned count stays below the period
  p_left_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !center_s && per_s != '0) |-> (cnt_q < per_s));
  // R4: center-aligned count never exceeds the period
  p_center_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && center_s) |-> (cnt_q <= per_s));
  // R6: shadows change only on a boundary
  p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load) |=> ($stable(per_s) && $stable(duty_s) && $stable(center_s)));
  // R7: a disabled channel rests at zero counting up
  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0 && !down_q));
  // R2: no tick, no movement
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             en_i,
  input  logic             pol_i,
  input  logic             center_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic in_duty;

  assign in_duty = pwm_in_duty(PWM_ARG_W'(cnt_i), PWM_ARG_W'(duty_i),
                               PWM_ARG_W'(per_i), center_i, down_i);
  assign pwm_o   = (en_i && in_duty) ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 center_i,
  input  logic                 pol_i,
  input  logic [PWM_SEL_W-1:0] clk_sel_i,
  input  logic [DIV_W-1:0]     div_a_i,
  input  logic [DIV_W-1:0]     div_b_i,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [CNT_W-1:0]     duty_i,
  output logic                 pwm_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt, per_s, duty_s;
  logic             down, center_s, boundary;

  pwm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sel_i(clk_sel_i),
    .div_a_i(div_a_i), .div_b_i(div_b_i), .tick_o(tick));

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .center_i(center_i), .period_i(period_i), .duty_i(duty_i),
    .cnt_o(cnt), .down_o(down), .center_o(center_s),
    .per_o(per_s), .duty_o(duty_s), .load_o(boundary));

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .en_i(en_i), .pol_i(pol_i), .center_i(center_s), .down_i(down),
    .cnt_i(cnt), .per_i(per_s), .duty_i(duty_s), .pwm_o(pwm_o));

  // R5: a zero duty value keeps the output at the polarity level
  p_const_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_s == '0) |-> (pwm_o == pol_i));
  // R5: a duty value at or above the period keeps the output inactive
  p_const_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_s >= per_s) |-> (pwm_o == !pol_i));
endmodule

// File: tb/tb_pwm_channel.sv
module tb_pwm_channel;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LIM = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b0, center = 1'b0, pol = 1'b1;
  logic [3:0]  sel = '0;
  logic [7:0]  div_a = '0, div_b = '0;
  logic [15:0] per = '0, duty = '0;
  logic        pwm;
  int          checks = 0, errors = 0, cyc = 0;

  pwm_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .center_i(center), .pol_i(pol),
    .clk_sel_i(sel), .div_a_i(div_a), .div_b_i(div_b),
    .period_i(per), .duty_i(duty), .pwm_o(pwm));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int divisor(input int s, input int a, input int b);
    if (s <= 10) return 1 << s;
    if (s == 11) return a;
    if (s == 12) return b;
    return 0;
  endfunction
  function automatic int exp_per(input int d, input int p, input bit c);
    return c ? 2 * d * p : d * p;
  endfunction
  function automatic int exp_act(input int d, input int p, input int q, input bit c);
    return c ? 2 * d * (p - q) : d * (p - q);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int s, input int a, input int b, input bit c,
                       input bit pl, input int p, input int d);
    @(negedge clk);
    en = 1'b0; sel = 4'(s); div_a = 8'(a); div_b = 8'(b);
    center = c; pol = pl; per = 16'(p); duty = 16'(d);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev, s;
    int n = 0;
    prev = (pwm == pol);
    ok = 1'b0;
    while (n < LIM) begin
      @(negedge clk);
      n++;
      s = (pwm == pol);
      if (s && !prev) begin ok = 1'b1; break; end
      prev = s;
    end
  endtask

  task automatic count_period(output int p, output int a);
    bit prev, s;
    s = 1'b1; p = 0; a = 0;
    do begin
      p++;
      if (s) a++;
      @(negedge clk);
      prev = s;
      s = (pwm == pol);
    end while (!(s && !prev) && p < LIM);
  endtask

  task automatic measure(input string req, input int ep, input int ea);
    bit ok;
    int p, a;
    wait_rise(ok);
    if (!ok) begin
      check(req, -1, ep);
    end else begin
      count_period(p, a);
      check(req, p, ep);
      check(req, a, ea);
    end
  endtask

  task automatic hold_level(input string req, input bit lvl, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm != lvl) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<190000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset output inactive", int'(pwm), 0);

    setup(0, 0, 0, 0, 1, 10, 3);
    measure("R3 left sel0", exp_per(1, 10, 0), exp_act(1, 10, 3, 0));
    setup(10, 0, 0, 0, 1, 3, 1);
    measure("R1 prescale 1024", exp_per(1024, 3, 0), exp_act(1024, 3, 1, 0));
    setup(3, 0, 0, 0, 1, 4, 1);
    measure("R1 prescale 8", exp_per(8, 4, 0), exp_act(8, 4, 1, 0));
    setup(2, 0, 0, 1, 1, 5, 2);
    measure("R4 center", exp_per(4, 5, 1), exp_act(4, 5, 2, 1));
    setup(11, 3, 0, 0, 1, 4, 1);
    measure("R2 divider A", exp_per(3, 4, 0), exp_act(3, 4, 1, 0));
    setup(12, 0, 5, 1, 1, 3, 1);
    measure("R2 divider B center", exp_per(5, 3, 1), exp_act(5, 3, 1, 1));
    setup(0, 0, 0, 0, 0, 8, 2);
    measure("R8 polarity low", exp_per(1, 8, 0), exp_act(1, 8, 2, 0));

    setup(0, 0, 0, 0, 1, 6, 0);
    hold_level("R5 duty zero constant", 1'b1, 200);
    setup(1, 0, 0, 1, 1, 6, 6);
    hold_level("R5 duty equal period constant", 1'b0, 200);
    setup(0, 0, 0, 0, 0, 6, 9);
    hold_level("R5 duty above period constant", 1'b1, 200);

    setup(11, 0, 0, 0, 1, 4, 2);
    hold_level("R2 factor zero holds", 1'b0, 200);
    setup(14, 4, 4, 0, 1, 4, 2);
    hold_level("R2 code 14 holds", 1'b0, 200);

    begin : boundary_update
      bit ok;
      int p, a;
      setup(0, 0, 0, 0, 1, 10, 2);
      wait_rise(ok);
      duty = 16'd6;
      count_period(p, a);
      check("R6 old duty kept in period", a, 8);
      check("R6 period across update", p, 14);
      count_period(p, a);
      check("R6 new duty after boundary", a, 4);
    end

    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R7 disabled output inactive", int'(pwm), 0);
    pol = 1'b0;
    @(negedge clk);
    check("R7 disabled follows polarity", int'(pwm), 1);

    for (int t = 0; t < 20; t++) begin
      int s, a, b, d, p, q, mx;
      bit c, pl;
      s = $urandom_range(12, 0);
      if (s > 8 && s < 11) s = s - 4;
      a = $urandom_range(8, 1);
      b = $urandom_range(8, 1);
      c = 1'($urandom_range(1, 0));
      pl = 1'($urandom_range(1, 0));
      d = divisor(s, a, b);
      mx = 3000 / (d * (c ? 2 : 1));
      if (mx > 40) mx = 40;
      if (mx < 2) mx = 2;
      p = $urandom_range(mx, 2);
      q = $urandom_range(p - 1, 1);
      setup(s, a, b, c, pl, p, q);
      measure(c ? "R4 random center" : "R3 random left",
              exp_per(d, p, c), exp_act(d, p, q, c));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule